// File: doc/BRIEF.md
# Multi-Format Audio Serial Port

This block is a master-mode serial audio port. It divides the system clock down to a bit clock and generates a frame sync. It shifts out one stereo pair per frame, left word first, MSB first. A receive shifter uses the same bit clock and frame sync and returns each captured stereo pair as one parallel transfer. Stereo pairs enter and leave through valid/ready handshakes.

A 3-bit format code selects among four framings: I2S, left-justified and two DSP variants. The formats differ in three ways: the active level of the frame sync, its length (a whole word or a single bit), and whether it leads the first data bit by one bit clock. The bit-clock polarity is the same in every format. Word width runs from 8 to 32 bits, and a frame is twice the word width. Format, width and divider are captured while the port is idle. The enable input starts and stops the port in a fixed order: the receiver comes up first and goes down last.

Top module: `aud_serial_port`

## Requirements
- R1: After reset, bclk_o, sd_o, fs_o, rx_valid_o, underrun_o, err_o, rx_active_o and tx_active_o are 0, and tx_ready_o is 1. The reset format is left-justified with 16-bit words.
- R2: On a rising en_i, rx_active_o rises one cycle before tx_active_o. On a falling en_i, tx_active_o drops one cycle before rx_active_o.
- R3: bclk_o is low whenever the port is stopped. Each half period of the bit clock lasts div_i+1 system cycles. In every format, sd_o changes only together with a falling edge of bclk_o.
- R4: Format code 0 (I2S) drives fs_o low for W bit clocks. The fall of fs_o comes one bit clock before the left MSB, during the last bit of the previous frame. fs_o idles high.
- R5: Format code 1 (left-justified) drives fs_o high for W bit clocks. It starts in the same bit as the left MSB and idles low.
- R6: Format code 2 (DSP-A) drives fs_o high for exactly one bit clock, one bit before the left MSB, for any W.
- R7: Format code 3 (DSP-B) drives fs_o high for exactly one bit clock, in the same bit as the left MSB, for any W.
- R8: Each frame carries the low W bits of tx_left_i, MSB first, followed by the low W bits of tx_right_i. Bits above W are ignored. W is taken from wlen_i, range 8..32.
- R9: The receiver samples sd_i on rising bclk_o with the transmitter's framing. It presents each complete pair on rx_left_o/rx_right_o (low W bits) with rx_valid_o. rx_valid_o is held until rx_ready_i.
- R10: If no pair is pending when a frame starts, the frame carries zeros and underrun_o sets. underrun_o stays set until reset.
- R11: A format code of 4..7, or a wlen_i outside 8..32, sets err_o one cycle later. While err_o is set, en_i cannot start the port.
- R12: tx_ready_o is high when the pending pair register is empty, and also in the cycle a frame start consumes it. A source that answers every ready therefore streams pairs with no underrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run request |
| fmt_i | input | 3 | Format code (0 I2S, 1 left-justified, 2 DSP-A, 3 DSP-B) |
| wlen_i | input | 6 | Word width in bits |
| div_i | input | 8 | Bit-clock half period minus one, in system cycles |
| tx_left_i | input | 32 | Left sample to send |
| tx_right_i | input | 32 | Right sample to send |
| tx_valid_i | input | 1 | Transmit pair valid |
| tx_ready_o | output | 1 | Transmit pair accepted |
| rx_left_o | output | 32 | Received left sample |
| rx_right_o | output | 32 | Received right sample |
| rx_valid_o | output | 1 | Received pair valid |
| rx_ready_i | input | 1 | Received pair taken |
| bclk_o | output | 1 | Bit clock |
| fs_o | output | 1 | Frame sync |
| sd_o | output | 1 | Serial data out |
| sd_i | input | 1 | Serial data in |
| rx_active_o | output | 1 | Receiver enabled |
| tx_active_o | output | 1 | Transmitter enabled |
| underrun_o | output | 1 | Sticky underrun |
| err_o | output | 1 | Unsupported configuration |

## Verification
Two events can land in the same system cycle: a frame start loading the pending pair into the shifter, and the handshake that refills that pair register. The bench triggers this by streaming with a source that offers the next pair as soon as tx_ready_o rises. With the register full, ready only rises in the load cycle, so every refill after the first coincides with a load. The serial output is looped back to the receiver. The test passes if four pairs come back in order and underrun_o stays clear until the stream runs dry.

// File: rtl/aud_serial_pkg.sv
package aud_serial_pkg;

  typedef enum logic [2:0] {
    FMT_I2S  = 3'd0,
    FMT_LJ   = 3'd1,
    FMT_DSPA = 3'd2,
    FMT_DSPB = 3'd3
  } fmt_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RXON,
    ST_RUN,
    ST_TXOFF
  } seq_t;

  // sync leads first data bit by one bit clock
  function automatic logic fmt_early(fmt_t f);
    return (f == FMT_I2S) || (f == FMT_DSPA);
  endfunction

  // single-bit frame sync
  function automatic logic fmt_pulse(fmt_t f);
    return (f == FMT_DSPA) || (f == FMT_DSPB);
  endfunction

  function automatic logic fmt_actlow(fmt_t f);
    return f == FMT_I2S;
  endfunction

endpackage

// File: rtl/aud_serial_clkgen.sv
module aud_serial_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             bclk_o,
  output logic             rise_o,
  output logic             fall_o
);

  logic [DIV_W-1:0] cnt_q;
  logic             tick;

  assign tick   = run_i && (cnt_q == div_i);
  assign rise_o = tick && !bclk_o;
  assign fall_o = tick && bclk_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      bclk_o <= 1'b0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      bclk_o <= 1'b0;
    end else if (tick) begin
      cnt_q  <= '0;
      bclk_o <= ~bclk_o;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/aud_serial_framer.sv
module aud_serial_framer
  import aud_serial_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int WW = $clog2(DATA_W + 1),
  localparam int PW = $clog2(2 * DATA_W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          fall_i,
  input  fmt_t          fmt_i,
  input  logic [WW-1:0] wlen_i,
  output logic [PW-1:0] q_cur_o,
  output logic [PW-1:0] q_nxt_o,
  output logic          fs_o
);

  logic [PW-1:0] pos_q, pos_nx, w_p, last_p;
  logic          early, act;

  assign w_p    = PW'(wlen_i);
  assign last_p = w_p + w_p - PW'(1);
  assign early  = fmt_early(fmt_i);

  // data index carried by a bit-clock position
  function automatic logic [PW-1:0] q_of(input logic [PW-1:0] pp, input logic e,
                                         input logic [PW-1:0] lst);
    if (!e) return pp;
    return (pp == '0) ? lst : pp - PW'(1);
  endfunction

  assign pos_nx  = (pos_q == last_p) ? '0 : pos_q + PW'(1);
  assign q_cur_o = q_of(pos_q, early, last_p);
  assign q_nxt_o = q_of(fall_i ? pos_nx : pos_q, early, last_p);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pos_q <= '1;
    else if (!run_i) pos_q <= last_p;
    else if (fall_i) pos_q <= pos_nx;
  end

  assign act  = fmt_pulse(fmt_i) ? (pos_q == '0) : (pos_q < w_p);
  assign fs_o = act ^ fmt_actlow(fmt_i);

endmodule

// File: rtl/aud_serial_tx.sv
module aud_serial_tx #(
  parameter int DATA_W = 32,
  localparam int WW = $clog2(DATA_W + 1),
  localparam int PW = $clog2(2 * DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              fall_i,
  input  logic [PW-1:0]     q_nxt_i,
  input  logic [WW-1:0]     wlen_i,
  input  logic [DATA_W-1:0] left_i,
  input  logic [DATA_W-1:0] right_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic              sd_o,
  output logic              underrun_o
);

  logic [DATA_W-1:0] pend_l_q, pend_r_q, shreg_q, rhold_q;
  logic              pend_q, at_load, at_mid, accept;
  logic [WW-1:0]     sh_amt;

  assign sh_amt  = WW'(DATA_W) - wlen_i;
  assign at_load = fall_i && (q_nxt_i == '0);
  assign at_mid  = fall_i && (q_nxt_i == PW'(wlen_i));
  assign ready_o = !pend_q || at_load;
  assign accept  = valid_i && ready_o;
  assign sd_o    = shreg_q[DATA_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= 1'b0;
      pend_l_q <= '0;
      pend_r_q <= '0;
    end else if (accept) begin
      pend_q   <= 1'b1;
      pend_l_q <= left_i;
      pend_r_q <= right_i;
    end else if (at_load) begin
      pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q    <= '0;
      rhold_q    <= '0;
      underrun_o <= 1'b0;
    end else if (!run_i) begin
      shreg_q <= '0;
      rhold_q <= '0;
    end else if (at_load) begin
      if (pend_q) begin
        shreg_q <= pend_l_q << sh_amt;
        rhold_q <= pend_r_q << sh_amt;
      end else begin
        shreg_q    <= '0;
        rhold_q    <= '0;
        underrun_o <= 1'b1;
      end
    end else if (at_mid) begin
      shreg_q <= rhold_q;
    end else if (fall_i) begin
      shreg_q <= shreg_q << 1;
    end
  end

endmodule

// File: rtl/aud_serial_rx.sv
module aud_serial_rx #(
  parameter int DATA_W = 32,
  localparam int WW = $clog2(DATA_W + 1),
  localparam int PW = $clog2(2 * DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              en_i,
  input  logic              rise_i,
  input  logic [PW-1:0]     q_cur_i,
  input  logic [WW-1:0]     wlen_i,
  input  logic              sd_i,
  input  logic              ready_i,
  output logic [DATA_W-1:0] left_o,
  output logic [DATA_W-1:0] right_o,
  output logic              valid_o
);

  logic [DATA_W-1:0] sh_q, sh_nx, lcap_q, mask;
  logic [DATA_W:0]   mask_ext;
  logic [PW-1:0]     w_p, last_p;
  logic              primed_q, sample;

  assign mask_ext = ({{DATA_W{1'b0}}, 1'b1} << wlen_i) - 1'b1;
  assign mask     = mask_ext[DATA_W-1:0];
  assign w_p      = PW'(wlen_i);
  assign last_p   = w_p + w_p - PW'(1);
  assign sh_nx    = {sh_q[DATA_W-2:0], sd_i};
  assign sample   = rise_i && en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q     <= '0;
      lcap_q   <= '0;
      primed_q <= 1'b0;
      left_o   <= '0;
      right_o  <= '0;
      valid_o  <= 1'b0;
    end else begin
      if (valid_o && ready_i) valid_o <= 1'b0;
      if (!run_i) primed_q <= 1'b0;
      else if (sample) begin
        sh_q <= sh_nx;
        if (q_cur_i == '0) primed_q <= 1'b1;
        if (q_cur_i == w_p - PW'(1)) lcap_q <= sh_nx & mask;
        // skip a tail word left from before start
        if (q_cur_i == last_p && primed_q) begin
          left_o  <= lcap_q;
          right_o <= sh_nx & mask;
          valid_o <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/aud_serial_port.sv
module aud_serial_port
  import aud_serial_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 8,
  parameter int MIN_W  = 8,
  localparam int WW = $clog2(DATA_W + 1),
  localparam int PW = $clog2(2 * DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [2:0]        fmt_i,
  input  logic [WW-1:0]     wlen_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [DATA_W-1:0] tx_left_i,
  input  logic [DATA_W-1:0] tx_right_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic [DATA_W-1:0] rx_left_o,
  output logic [DATA_W-1:0] rx_right_o,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  output logic              bclk_o,
  output logic              fs_o,
  output logic              sd_o,
  input  logic              sd_i,
  output logic              rx_active_o,
  output logic              tx_active_o,
  output logic              underrun_o,
  output logic              err_o
);

  seq_t             st_q;
  fmt_t             cfg_fmt_q;
  logic [WW-1:0]    cfg_w_q;
  logic [DIV_W-1:0] cfg_div_q;
  logic             bad, rise, fall;
  logic [PW-1:0]    q_cur, q_nxt;

  assign bad = (fmt_i > 3'd3) || (wlen_i < WW'(MIN_W)) || (wlen_i > WW'(DATA_W));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o     <= 1'b0;
      cfg_fmt_q <= FMT_LJ;
      cfg_w_q   <= WW'(16);
      cfg_div_q <= '0;
    end else begin
      err_o <= bad;
      if (st_q == ST_IDLE && !bad) begin
        cfg_fmt_q <= fmt_t'(fmt_i);
        cfg_w_q   <= wlen_i;
        cfg_div_q <= div_i;
      end
    end
  end

  // receiver up first, transmitter down first
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else begin
      unique case (st_q)
        ST_IDLE:  if (en_i && !err_o) st_q <= ST_RXON;
        ST_RXON:  st_q <= en_i ? ST_RUN : ST_IDLE;
        ST_RUN:   if (!en_i) st_q <= ST_TXOFF;
        ST_TXOFF: st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  assign rx_active_o = (st_q != ST_IDLE);
  assign tx_active_o = (st_q == ST_RUN);

  aud_serial_clkgen #(.DIV_W(DIV_W)) i_clkgen (
    .clk_i, .rst_ni,
    .run_i  (tx_active_o),
    .div_i  (cfg_div_q),
    .bclk_o (bclk_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  aud_serial_framer #(.DATA_W(DATA_W)) i_framer (
    .clk_i, .rst_ni,
    .run_i   (tx_active_o),
    .fall_i  (fall),
    .fmt_i   (cfg_fmt_q),
    .wlen_i  (cfg_w_q),
    .q_cur_o (q_cur),
    .q_nxt_o (q_nxt),
    .fs_o    (fs_o)
  );

  aud_serial_tx #(.DATA_W(DATA_W)) i_tx (
    .clk_i, .rst_ni,
    .run_i      (tx_active_o),
    .fall_i     (fall),
    .q_nxt_i    (q_nxt),
    .wlen_i     (cfg_w_q),
    .left_i     (tx_left_i),
    .right_i    (tx_right_i),
    .valid_i    (tx_valid_i),
    .ready_o    (tx_ready_o),
    .sd_o       (sd_o),
    .underrun_o (underrun_o)
  );

  aud_serial_rx #(.DATA_W(DATA_W)) i_rx (
    .clk_i, .rst_ni,
    .run_i   (tx_active_o),
    .en_i    (rx_active_o),
    .rise_i  (rise),
    .q_cur_i (q_cur),
    .wlen_i  (cfg_w_q),
    .sd_i    (sd_i),
    .ready_i (rx_ready_i),
    .left_o  (rx_left_o),
    .right_o (rx_right_o),
    .valid_o (rx_valid_o)
  );

endmodule

// File: rtl/aud_serial_port_chk.sv
module aud_serial_port_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tx_active_o,
  input logic rx_active_o,
  input logic bclk_o,
  input logic sd_o,
  input logic underrun_o,
  input logic err_o,
  input logic rx_valid_o,
  input logic rx_ready_i
);

  // R2
  tx_needs_rx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_active_o |-> rx_active_o);

  // R2
  rx_leads_tx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_active_o) |-> $past(rx_active_o));

  // R3
  bclk_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_active_o && !$past(tx_active_o)) |-> !bclk_o);

  // R3
  sd_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_active_o && $past(tx_active_o) && !$stable(sd_o)) |-> $fell(bclk_o));

  // R9
  rx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && !rx_ready_i) |=> rx_valid_o);

  // R10
  underrun_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |=> underrun_o);

  // R11
  err_blocks_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !rx_active_o) |=> !rx_active_o);

endmodule

bind aud_serial_port aud_serial_port_chk i_chk (.*);

// File: tb/test_aud_serial_port.sv
`timescale 1ns/1ps
module test_aud_serial_port;

  localparam int MAXS = 140;

  logic        clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic [2:0]  fmt = 3'd1;
  logic [5:0]  wlen = 6'd16;
  logic [7:0]  div = 8'd0;
  logic [31:0] tx_l = '0, tx_r = '0;
  logic        tx_valid = 1'b0, rx_ready = 1'b1;
  logic        tx_ready, rx_valid, bclk, fs, sd, rx_act, tx_act, underrun, err;
  logic [31:0] rx_l, rx_r;

  int tests = 0, fails = 0, cyc = 0, viol = 0;
  int nsamp = 0, nrx = 0;
  logic rec = 1'b0;
  logic fs_s [MAXS], sd_s [MAXS];
  int   rise_t [MAXS];
  logic [31:0] rxl [8], rxr [8];
  logic p_bclk = 1'b0, p_sd = 1'b0, p_tx = 1'b0;

  always #10 clk = ~clk;

  aud_serial_port i_aud_serial_port (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .fmt_i(fmt), .wlen_i(wlen), .div_i(div),
    .tx_left_i(tx_l), .tx_right_i(tx_r), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
    .rx_left_o(rx_l), .rx_right_o(rx_r), .rx_valid_o(rx_valid), .rx_ready_i(rx_ready),
    .bclk_o(bclk), .fs_o(fs), .sd_o(sd), .sd_i(sd),
    .rx_active_o(rx_act), .tx_active_o(tx_act), .underrun_o(underrun), .err_o(err)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      fails = fails + 1;
      tests = tests + 1;
      $display("FAIL watchdog: run hung (actual %0d cycles, expected fewer)", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (!rec) begin
      nsamp <= 0;
      nrx   <= 0;
    end else begin
      if (bclk && !p_bclk && nsamp < MAXS) begin
        fs_s[nsamp]   <= fs;
        sd_s[nsamp]   <= sd;
        rise_t[nsamp] <= cyc;
        nsamp <= nsamp + 1;
      end
      if (rx_valid && rx_ready && nrx < 8) begin
        rxl[nrx] <= rx_l;
        rxr[nrx] <= rx_r;
        nrx <= nrx + 1;
      end
    end
    if (tx_act && p_tx && sd != p_sd && !(p_bclk && !bclk)) viol <= viol + 1;
    p_bclk <= bclk;
    p_sd   <= sd;
    p_tx   <= tx_act;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests = tests + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    en = 1'b0; tx_valid = 1'b0; rec = 1'b0; rx_ready = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic push_pair(input logic [31:0] l, input logic [31:0] r);
    @(negedge clk);
    tx_l = l; tx_r = r; tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(posedge clk);
    #1 tx_valid = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    // R1
    chk({bclk, sd, fs, rx_valid, underrun, err, rx_act, tx_act} == 8'h00, "R1 outputs",
        {bclk, sd, fs, rx_valid, underrun, err, rx_act, tx_act}, 0);
    chk(tx_ready == 1'b1, "R1 ready", tx_ready, 1);
  endtask

  task automatic t_order();
    do_reset();
    @(negedge clk); en = 1'b1;
    @(negedge clk);
    chk(rx_act && !tx_act, "R2 start rx first", {rx_act, tx_act}, 2'b10);
    @(negedge clk);
    chk(rx_act && tx_act, "R2 start both", {rx_act, tx_act}, 2'b11);
    en = 1'b0;
    @(negedge clk);
    chk(rx_act && !tx_act, "R2 stop tx first", {rx_act, tx_act}, 2'b10);
    @(negedge clk);
    chk(!rx_act && !tx_act, "R2 stop both", {rx_act, tx_act}, 2'b00);
  endtask

  task automatic t_fmt(input logic [2:0] m, input int w, input int dv,
                       input logic [31:0] l, input logic [31:0] r, input string tg);
    int n, off, bad_fs, bad_sd, bad_z;
    logic act, eb, ea;
    logic [31:0] msk, lm, rm;
    do_reset();
    fmt = m; wlen = 6'(w); div = 8'(dv);
    push_pair(l, r);
    rec = 1'b1; en = 1'b1;
    n = 4 * w + 3;
    wait (nsamp >= n);
    @(negedge clk); en = 1'b0;
    msk = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    lm = l & msk; rm = r & msk;
    act = (m != 3'd0);
    off = (m == 3'd0 || m == 3'd2) ? 1 : 0;
    bad_fs = 0; bad_sd = 0; bad_z = 0;
    chk(fs_s[0] != act, {tg, " idle sync level"}, fs_s[0], !act);
    for (int k = 0; k < 2 * w; k++) begin
      ea = (m >= 3'd2) ? (k == 0) : (k < w);
      if ((fs_s[1 + k] == act) != ea) bad_fs++;
    end
    chk(bad_fs == 0, {tg, " sync shape"}, bad_fs, 0);
    for (int j = 0; j < 2 * w; j++) begin
      eb = (j < w) ? lm[w - 1 - j] : rm[2 * w - 1 - j];
      if (sd_s[1 + off + j] != eb) bad_sd++;
      if (sd_s[1 + off + 2 * w + j] != 1'b0) bad_z++;
    end
    chk(bad_sd == 0, {tg, " R8 data bits"}, bad_sd, 0);
    chk(bad_z == 0 && underrun, "R10 zero frame and flag", {bad_z, underrun}, 1);
    chk(nrx >= 1 && rxl[0] == lm && rxr[0] == rm, "R9 loopback pair",
        {rxl[0], rxr[0]}, {lm, rm});
    chk(rise_t[2] - rise_t[1] == 2 * (dv + 1), "R3 bit period", rise_t[2] - rise_t[1], 2 * (dv + 1));
    rec = 1'b0;
    repeat (4) @(negedge clk);
    chk(!bclk && !tx_act, "R3 idle low after stop", bclk, 0);
  endtask

  task automatic t_stream();
    logic [31:0] el, er;
    int bad;
    do_reset();
    fmt = 3'd1; wlen = 6'd16; div = 8'd1;
    rec = 1'b1;
    push_pair(32'h1000, 32'hE000);
    en = 1'b1;
    for (int k = 1; k < 4; k++) push_pair(32'h1000 + k * 32'h111, 32'hE000 + k * 32'h22);
    wait (nrx >= 3);
    chk(underrun == 1'b0, "R12 no underrun while streaming", underrun, 0);
    wait (nrx >= 4);
    bad = 0;
    for (int k = 0; k < 4; k++) begin
      el = 32'h1000 + k * 32'h111;
      er = 32'hE000 + k * 32'h22;
      if (rxl[k] != el || rxr[k] != er) bad++;
    end
    chk(bad == 0, "R12 streamed pairs in order", bad, 0);
    en = 1'b0; rec = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_bad(input logic [2:0] m, input int w);
    int seen;
    do_reset();
    fmt = m; wlen = 6'(w);
    @(negedge clk); en = 1'b1;
    seen = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (bclk || rx_act || sd) seen++;
    end
    chk(err == 1'b1 && seen == 0, "R11 bad config blocks start", {err, seen[7:0]}, 9'h100);
    fmt = 3'd1; wlen = 6'd16;
    repeat (4) @(negedge clk);
    chk(err == 1'b0 && rx_act, "R11 recovers with valid config", {err, rx_act}, 2'b01);
    en = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_order();
    t_fmt(3'd0, 8, 0, 32'hFFA5, 32'h3C, "R4 I2S w8");
    t_fmt(3'd1, 8, 2, 32'hC3, 32'h5A, "R5 LJ w8");
    t_fmt(3'd2, 8, 0, 32'h81, 32'h7E, "R6 DSPA w8");
    t_fmt(3'd2, 12, 1, 32'hABC, 32'h123, "R6 DSPA w12");
    t_fmt(3'd3, 8, 0, 32'h96, 32'h69, "R7 DSPB w8");
    t_fmt(3'd3, 32, 0, 32'hDEADBEEF, 32'h8000_0001, "R7 DSPB w32");
    t_fmt(3'd0, 32, 0, 32'h8765_4321, 32'h0F0F_F0F1, "R4 I2S w32");
    t_stream();
    t_bad(3'd4, 16);
    t_bad(3'd1, 7);
    chk(viol == 0, "R3 data moved off falling edge", viol, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule